// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block lets a host read and write the control registers of an external AC'97 codec over the command slots of the serial link. The host loads transmit holding registers for the command-address slot (slot 1), the command-data slot (slot 2) and the general-purpose slot (slot 12). At each frame boundary the engine places committed words into the outgoing frame with their tag bits. It captures returned words from incoming frames into receive holding registers, and it reports per-slot busy, empty and valid flags.

A write is issued by loading slot 2 first and then slot 1. The slot 1 load commits the command, and slot 2 rides in the same frame. A read is a slot 1 word with its request bit set. The codec's answer is accepted only in the frame that follows the one carrying the request. A main control word enables the interface, gates every slot direction separately and picks which of up to four codecs is addressed. A reset control drives the codec's active-low reset and holds it low for a programmable minimum time. The serial shifter is outside the block and is seen as a one-cycle frame strobe with parallel slot words.

Top module: `codec_regs_top`

## Requirements
- R1: After reset, no tag is driven on the outgoing frame, the flag word reads 0xA80 (all three transmit-empty bits set), the main control word reads 0 and the codec reset output is low.
- R2: Register map (hostAddr): 0 slot 1 transmit, 1 slot 2 transmit, 2 slot 12 transmit, 3 slot 1 receive, 4 slot 2 receive, 5 slot 12 receive, 6 flags, 7 main control, 8 reset control. A slot 1 commit goes out in the next frame with frameTag bit 0, and a pending slot 2 word goes with it under frameTag bit 1. Slot 1 carries the register index in bits 18:12, and slot 2 carries the value in bits 19:4.
- R3: A slot 2 word is never sent on its own. It stays pending, with its transmit-busy bit (flag bit 3) set and its transmit-empty bit (flag bit 9) clear, until a slot 1 commit sends it.
- R4: Each slot's transmit-busy flag (bit 1 for slot 1) rises on the host load and stays high through the frame boundary that launches the word. It falls only at the next frame boundary, after the word has been shifted out. Transmit-empty (bit 7 for slot 1) is set again as soon as the word is launched.
- R5: A pending slot is launched only while the interface enable (main control bit 0) and that slot's transmit enable (bits 1, 2 and 3 for slots 1, 2 and 12) are set. Otherwise the word waits with its busy flag set.
- R6: When a slot 1 word with bit 19 set has been shifted out, the receive-busy flags (bits 0 and 2) are set for exactly one frame. Tagged slot 1 and slot 2 words arriving at the end of that frame are captured, and their valid flags (bits 6 and 8) are set. The captured slot 1 word echoes the requested index in bits 18:12, and slot 2 carries the read data in bits 19:4.
- R7: Tagged slot 1 or slot 2 words arriving while no read response is awaited are ignored: the receive registers and valid flags keep their values.
- R8: Reading a receive holding register clears its valid flag.
- R9: Capture into a slot additionally requires the interface enable and that slot's receive enable (main control bits 4, 5 and 6 for slots 1, 2 and 12).
- R10: Slot 12 is independent of slots 1 and 2. A load is sent in the next enabled frame under frameTag bit 2, and a tagged incoming slot 12 word is captured at any enabled frame, setting valid flag bit 10.
- R11: The codec reset output follows reset control bit 0 (1 releases the reset). After any assertion it stays low for at least RST_HOLD_CYCLES clock cycles, even if a release is written sooner.
- R12: Main control bits 11:10 select the codec number (0 to 3), which is presented on frameCodecId with every launched slot 1 command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (clears receive valid on receive addresses) |
| hostAddr | input | 4 | Host register address |
| hostWdata | input | 20 | Host write data |
| hostRdata | output | 20 | Host read data, combinational from hostAddr |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| rxTag | input | 3 | Tag bits of incoming slots 1, 2, 12 at the strobe |
| rxSlot1 | input | 20 | Incoming slot 1 word |
| rxSlot2 | input | 20 | Incoming slot 2 word |
| rxSlot12 | input | 20 | Incoming slot 12 word |
| frameTag | output | 3 | Tag bits of the outgoing frame for slots 1, 2, 12 |
| frameSlot1 | output | 20 | Outgoing slot 1 word |
| frameSlot2 | output | 20 | Outgoing slot 2 word |
| frameSlot12 | output | 20 | Outgoing slot 12 word |
| frameCodecId | output | 2 | Codec number for the outgoing command |
| codecResetN | output | 1 | Active-low codec reset |

## Verification
A wrong pending or in-flight bit in this block appears at the outgoing frame at the very next strobe: a missing or extra tag, a slot 2 word launched without slot 1, or a stale word. A slot can also hang busy, which the flag word shows on the next host read. A wrong response-window state shows one frame later, as a returned word that is captured when it should be dropped or dropped when it should be captured, visible through the valid flags and the receive register contents. A reset hold counter that is off by a few cycles only shows at the moment the codec reset is released, so the bench samples just before and just after the expected release cycle.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 3;
  localparam int ADDR_W    = 4;
  localparam int CTRL_W    = 12;
  localparam int FLAG_W    = 4 * NUM_SLOTS;

  // slot indices
  localparam int SL_CMD  = 0;
  localparam int SL_DATA = 1;
  localparam int SL_GPIO = 2;

  // host addresses
  localparam int ADDR_TX0   = 0;
  localparam int ADDR_RX0   = ADDR_TX0 + NUM_SLOTS;
  localparam int ADDR_FLAGS = ADDR_RX0 + NUM_SLOTS;
  localparam int ADDR_MAIN  = ADDR_FLAGS + 1;
  localparam int ADDR_RST   = ADDR_MAIN + 1;

  // main control field positions
  localparam int CTRL_IFEN = 0;
  localparam int CTRL_TXEN = 1;
  localparam int CTRL_RXEN = CTRL_TXEN + NUM_SLOTS;
  localparam int CTRL_SEL  = 10;
  localparam int SEL_W     = 2;

  localparam int READ_BIT = 19;

  typedef struct packed {
    logic                 frameEdge;
    logic [NUM_SLOTS-1:0] loadTx;
    logic [NUM_SLOTS-1:0] launch;
    logic [NUM_SLOTS-1:0] capture;
  } strobe_t;
endpackage

// File: rtl/codec_regs_dp.sv
module codec_regs_dp
  import codec_regs_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strb,
  input  logic [ADDR_W-1:0]                  hostAddr,
  input  logic [SLOT_W-1:0]                  hostWdata,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]   rxWord,
  input  logic [FLAG_W-1:0]                  flags,
  input  logic [CTRL_W-1:0]                  mainCtrl,
  input  logic                               resetReq,
  output logic [SLOT_W-1:0]                  hostRdata,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   frameWord,
  output logic [NUM_SLOTS-1:0]               frameTag,
  output logic [SEL_W-1:0]                   frameCodecId,
  output logic                               slot1ReadBit
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] holdTx;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] holdRx;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdTx[i]    <= '0;
        holdRx[i]    <= '0;
        frameWord[i] <= '0;
      end else begin
        if (strb.loadTx[i])  holdTx[i]    <= hostWdata;
        if (strb.capture[i]) holdRx[i]    <= rxWord[i];
        if (strb.launch[i])  frameWord[i] <= holdTx[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameTag     <= '0;
      frameCodecId <= '0;
    end else if (strb.frameEdge) begin
      frameTag <= strb.launch;
      if (strb.launch[SL_CMD]) frameCodecId <= mainCtrl[CTRL_SEL +: SEL_W];
    end
  end

  assign slot1ReadBit = holdTx[SL_CMD][READ_BIT];

  always_comb begin
    hostRdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hostAddr == ADDR_W'(ADDR_TX0 + i)) hostRdata = holdTx[i];
      if (hostAddr == ADDR_W'(ADDR_RX0 + i)) hostRdata = holdRx[i];
    end
    if (hostAddr == ADDR_W'(ADDR_FLAGS)) hostRdata = SLOT_W'(flags);
    if (hostAddr == ADDR_W'(ADDR_MAIN))  hostRdata = SLOT_W'(mainCtrl);
    if (hostAddr == ADDR_W'(ADDR_RST))   hostRdata = SLOT_W'(resetReq);
  end

  // R3: slot 2 is only ever tagged together with slot 1
  a_r3_data_rides_cmd: assert property (@(posedge clk) disable iff (!rstN)
    frameTag[SL_DATA] |-> frameTag[SL_CMD]);
endmodule

// File: rtl/codec_regs_ctrl.sv
module codec_regs_ctrl
  import codec_regs_pkg::*;
#(
  parameter int RST_HOLD_CYCLES = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [CTRL_W-1:0]    wrData,
  input  logic                 frameStrobe,
  input  logic [NUM_SLOTS-1:0] rxTag,
  input  logic                 slot1ReadBit,
  output strobe_t              strb,
  output logic [CTRL_W-1:0]    mainCtrl,
  output logic                 resetReq,
  output logic [FLAG_W-1:0]    flags,
  output logic                 codecResetN
);
  localparam int CNT_W = $clog2(RST_HOLD_CYCLES + 1);

  logic                 ifEn;
  logic [NUM_SLOTS-1:0] txEn, rxEn;
  logic [NUM_SLOTS-1:0] pend, send, valid, txBusy, rxBusy;
  logic [NUM_SLOTS-1:0] loadTx, readRx, launch, capture;
  logic                 armed, sentRead;
  logic [CNT_W-1:0]     holdCnt;

  assign ifEn = mainCtrl[CTRL_IFEN];
  assign txEn = mainCtrl[CTRL_TXEN +: NUM_SLOTS];
  assign rxEn = mainCtrl[CTRL_RXEN +: NUM_SLOTS];

  always_comb begin
    launch[SL_CMD]  = frameStrobe & ifEn & txEn[SL_CMD] & pend[SL_CMD];
    launch[SL_DATA] = launch[SL_CMD] & txEn[SL_DATA] & pend[SL_DATA];
    launch[SL_GPIO] = frameStrobe & ifEn & txEn[SL_GPIO] & pend[SL_GPIO];
    capture[SL_CMD]  = frameStrobe & ifEn & armed & rxEn[SL_CMD] & rxTag[SL_CMD];
    capture[SL_DATA] = frameStrobe & ifEn & armed & rxEn[SL_DATA] & rxTag[SL_DATA];
    capture[SL_GPIO] = frameStrobe & ifEn & rxEn[SL_GPIO] & rxTag[SL_GPIO];
  end

  assign strb.frameEdge = frameStrobe;
  assign strb.loadTx    = loadTx;
  assign strb.launch    = launch;
  assign strb.capture   = capture;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign loadTx[i] = hostWr && (hostAddr == ADDR_W'(ADDR_TX0 + i));
    assign readRx[i] = hostRd && (hostAddr == ADDR_W'(ADDR_RX0 + i));
    assign txBusy[i] = pend[i] | send[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[i]  <= 1'b0;
        valid[i] <= 1'b0;
      end else begin
        pend[i] <= loadTx[i] | (pend[i] & ~launch[i]);
        if (capture[i])     valid[i] <= 1'b1;
        else if (readRx[i]) valid[i] <= 1'b0;
      end
    end

    if (i == SL_GPIO) begin : g_noresp
      assign rxBusy[i] = 1'b0;
    end else begin : g_resp
      assign rxBusy[i] = armed;
    end

    assign flags[2*i]                 = rxBusy[i];
    assign flags[2*i+1]               = txBusy[i];
    assign flags[2*NUM_SLOTS+2*i]     = valid[i];
    assign flags[2*NUM_SLOTS+2*i+1]   = ~pend[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      send     <= '0;
      sentRead <= 1'b0;
      armed    <= 1'b0;
    end else if (frameStrobe) begin
      send  <= launch;
      armed <= send[SL_CMD] & sentRead;
      if (launch[SL_CMD]) sentRead <= slot1ReadBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCtrl    <= '0;
      resetReq    <= 1'b0;
      holdCnt     <= CNT_W'(RST_HOLD_CYCLES);
      codecResetN <= 1'b0;
    end else begin
      if (hostWr && hostAddr == ADDR_W'(ADDR_MAIN)) mainCtrl <= wrData;
      if (hostWr && hostAddr == ADDR_W'(ADDR_RST))  resetReq <= wrData[0];
      if (!resetReq)         holdCnt <= CNT_W'(RST_HOLD_CYCLES);
      else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
      codecResetN <= resetReq && (holdCnt == 0);
    end
  end

  // checker: cycles the codec reset output has been low
  logic [CNT_W:0] lowCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                lowCnt <= '0;
    else if (codecResetN)     lowCnt <= '0;
    else if (lowCnt <= (CNT_W+1)'(RST_HOLD_CYCLES)) lowCnt <= lowCnt + 1'b1;
  end

  // R11: reset released only after the minimum hold
  a_r11_reset_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codecResetN) |-> lowCnt >= (CNT_W+1)'(RST_HOLD_CYCLES));

  // R4: slot 1 busy only ends at a frame boundary
  a_r4_busy_ends_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy[SL_CMD]) |-> $past(frameStrobe));

  // R8: a receive read with no simultaneous capture leaves the slot invalid
  a_r8_read_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    (readRx[SL_DATA] && !capture[SL_DATA]) |=> !valid[SL_DATA]);

  // R7: slot 1 capture only inside a response window
  a_r7_no_unsolicited: assert property (@(posedge clk) disable iff (!rstN)
    $rose(valid[SL_CMD]) |-> $past(armed));
endmodule

// File: rtl/codec_regs_top.sv
module codec_regs_top
  import codec_regs_pkg::*;
#(
  parameter int RST_HOLD_CYCLES = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [3:0]  hostAddr,
  input  logic [19:0] hostWdata,
  output logic [19:0] hostRdata,
  input  logic        frameStrobe,
  input  logic [2:0]  rxTag,
  input  logic [19:0] rxSlot1,
  input  logic [19:0] rxSlot2,
  input  logic [19:0] rxSlot12,
  output logic [2:0]  frameTag,
  output logic [19:0] frameSlot1,
  output logic [19:0] frameSlot2,
  output logic [19:0] frameSlot12,
  output logic [1:0]  frameCodecId,
  output logic        codecResetN
);
  strobe_t                          strb;
  logic [CTRL_W-1:0]                mainCtrl;
  logic                             resetReq;
  logic [FLAG_W-1:0]                flags;
  logic                             slot1ReadBit;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] rxWord, frameWord;

  assign rxWord[SL_CMD]  = rxSlot1;
  assign rxWord[SL_DATA] = rxSlot2;
  assign rxWord[SL_GPIO] = rxSlot12;
  assign frameSlot1  = frameWord[SL_CMD];
  assign frameSlot2  = frameWord[SL_DATA];
  assign frameSlot12 = frameWord[SL_GPIO];

  codec_regs_ctrl #(.RST_HOLD_CYCLES(RST_HOLD_CYCLES)) ctrl_i (
    .clk, .rstN, .hostWr, .hostRd, .hostAddr,
    .wrData(hostWdata[CTRL_W-1:0]),
    .frameStrobe, .rxTag, .slot1ReadBit,
    .strb, .mainCtrl, .resetReq, .flags, .codecResetN
  );

  codec_regs_dp dp_i (
    .clk, .rstN, .strb, .hostAddr, .hostWdata, .rxWord,
    .flags, .mainCtrl, .resetReq,
    .hostRdata, .frameWord, .frameTag, .frameCodecId, .slot1ReadBit
  );
endmodule

// File: tb/codec_regs_tb.sv
module codec_regs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 100;

  logic clk = 0, rstN = 0;
  logic hostWr = 0, hostRd = 0;
  logic [3:0] hostAddr = 0;
  logic [19:0] hostWdata = 0, hostRdata;
  logic frameStrobe = 0;
  logic [2:0] rxTag = 0;
  logic [19:0] rxSlot1 = 0, rxSlot2 = 0, rxSlot12 = 0;
  logic [2:0] frameTag;
  logic [19:0] frameSlot1, frameSlot2, frameSlot12;
  logic [1:0] frameCodecId;
  logic codecResetN;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // expected frames (scoreboard)
  logic [2:0]  expTag[$];
  logic [19:0] expW1[$], expW2[$], expW12[$];
  logic [1:0]  expCid[$];
  string       expReq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_regs_top #(.RST_HOLD_CYCLES(HOLD)) dut_i (.*);

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(int a, logic [19:0] d);
    @(negedge clk); hostWr = 1; hostAddr = 4'(a); hostWdata = d;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic hostRead(int a, output logic [19:0] d);
    @(negedge clk); hostRd = 1; hostAddr = 4'(a);
    #1 d = hostRdata;
    @(negedge clk); hostRd = 0;
  endtask

  task automatic readCheck(string req, int a, logic [19:0] exp);
    logic [19:0] d;
    hostRead(a, d);
    check(req, d, exp);
  endtask

  task automatic expectFrame(string req, logic [2:0] t, logic [19:0] w1, logic [19:0] w2,
                             logic [19:0] w12, logic [1:0] cid);
    expTag.push_back(t); expW1.push_back(w1); expW2.push_back(w2);
    expW12.push_back(w12); expCid.push_back(cid); expReq.push_back(req);
  endtask

  task automatic frameStep(logic [2:0] t, logic [19:0] r1, logic [19:0] r2, logic [19:0] r12);
    @(negedge clk); frameStrobe = 1; rxTag = t; rxSlot1 = r1; rxSlot2 = r2; rxSlot12 = r12;
    @(negedge clk); frameStrobe = 0; rxTag = 0;
  endtask

  // monitor: compare every outgoing frame against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (frameStrobe) begin
        @(negedge clk);
        if (expTag.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R2: unexpected frame, tag 0x%0h expected none", frameTag);
        end else begin
          logic [2:0] t;
          string r;
          t = expTag.pop_front(); r = expReq.pop_front();
          check(r, 20'(frameTag), 20'(t));
          if (t[0]) check(r, frameSlot1, expW1[0]);
          if (t[0]) check("R12", 20'(frameCodecId), 20'(expCid[0]));
          if (t[1]) check(r, frameSlot2, expW2[0]);
          if (t[2]) check(r, frameSlot12, expW12[0]);
          void'(expW1.pop_front()); void'(expW2.pop_front());
          void'(expW12.pop_front()); void'(expCid.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    check("R1", 20'(frameTag), 0);
    check("R1", 20'(codecResetN), 0);
    readCheck("R1", 6, 20'hA80);
    readCheck("R1", 7, 0);

    hostWrite(7, 20'h87F);   // enable all, codec 2
    // R3 slot 2 held alone
    hostWrite(1, 20'h12340);
    expectFrame("R3", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    readCheck("R3", 6, 20'h888);
    // R2/R4 write command
    hostWrite(0, 20'h1A000);
    readCheck("R4", 6, 20'h80A);
    expectFrame("R2", 3'b011, 20'h1A000, 20'h12340, 0, 2'd2);
    frameStep(0, 0, 0, 0);
    readCheck("R4", 6, 20'hA8A);
    expectFrame("R4", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    readCheck("R4", 6, 20'hA80);

    // R5 enable gating
    hostWrite(7, 20'h87D);
    hostWrite(0, 20'h05000);
    expectFrame("R5", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    readCheck("R5", 6, 20'hA02);
    hostWrite(7, 20'h87E);
    expectFrame("R5", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    hostWrite(7, 20'h87F);
    expectFrame("R5", 3'b001, 20'h05000, 0, 0, 2'd2);
    frameStep(0, 0, 0, 0);
    expectFrame("R5", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);

    // R6/R8/R12 read of register 0x26 on codec 1
    hostWrite(7, 20'h47F);
    hostWrite(0, 20'hA6000);
    expectFrame("R6", 3'b001, 20'hA6000, 0, 0, 2'd1);
    frameStep(0, 0, 0, 0);
    expectFrame("R6", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    readCheck("R6", 6, 20'hA85);
    expectFrame("R6", 3'b000, 0, 0, 0, 0);
    frameStep(3'b011, 20'h26000, 20'hBEEF0, 0);
    readCheck("R6", 6, 20'hBC0);
    begin
      logic [19:0] d;
      hostRead(3, d);
      check("R6", 20'(d[18:12]), 20'h26);
    end
    readCheck("R8", 6, 20'hB80);
    begin
      logic [19:0] d;
      hostRead(4, d);
      check("R6", 20'(d[19:4]), 20'hBEEF);
    end
    readCheck("R8", 6, 20'hA80);

    // R7 unsolicited response ignored
    expectFrame("R7", 3'b000, 0, 0, 0, 0);
    frameStep(3'b011, 20'h11000, 20'h55550, 0);
    readCheck("R7", 6, 20'hA80);
    readCheck("R7", 3, 20'h26000);

    // R9 slot 2 receive disabled
    hostWrite(7, 20'h45F);
    hostWrite(0, 20'h83000);
    expectFrame("R9", 3'b001, 20'h83000, 0, 0, 2'd1);
    frameStep(0, 0, 0, 0);
    expectFrame("R9", 3'b000, 0, 0, 0, 0);
    frameStep(0, 0, 0, 0);
    expectFrame("R9", 3'b000, 0, 0, 0, 0);
    frameStep(3'b011, 20'h03000, 20'h77770, 0);
    readCheck("R9", 6, 20'hAC0);
    readCheck("R9", 4, 20'hBEEF0);
    readCheck("R9", 3, 20'h03000);

    // R10 slot 12 independent
    hostWrite(7, 20'h47F);
    hostWrite(2, 20'h00ABC);
    expectFrame("R10", 3'b100, 0, 0, 20'h00ABC, 0);
    frameStep(0, 0, 0, 0);
    expectFrame("R10", 3'b000, 0, 0, 0, 0);
    frameStep(3'b100, 0, 0, 20'h12345);
    readCheck("R10", 6, 20'hE80);
    readCheck("R10", 5, 20'h12345);

    // R11 codec reset hold
    hostWrite(8, 20'h1);
    repeat (HOLD - 3) @(negedge clk);
    check("R11", 20'(codecResetN), 0);
    repeat (8) @(negedge clk);
    check("R11", 20'(codecResetN), 1);
    hostWrite(8, 20'h0);
    @(negedge clk);
    check("R11", 20'(codecResetN), 0);
    hostWrite(8, 20'h1);
    repeat (HOLD - 3) @(negedge clk);
    check("R11", 20'(codecResetN), 0);
    repeat (8) @(negedge clk);
    check("R11", 20'(codecResetN), 1);

    repeat (3) @(negedge clk);
    check("R2", 20'(expTag.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule